// File: doc/BRIEF.md
# Indirect PHY Register Access Sequencer

This block lets on-chip logic reach 16-bit PHY configuration registers that sit behind a narrow side channel instead of a memory map. The channel is one outgoing control word and one incoming status word. A request/acknowledge handshake with four phases moves every address, data value and strobe across it. A client issues a read or a write command with a 16-bit address and, for writes, 16-bit data. The block then steps through the control-word patterns on its own and reports the result.

Every phase raises one strobe bit and waits for the PHY acknowledge to go high. It then lowers the strobe and waits for the acknowledge to go low. The acknowledge is polled once every `POLL_GAP` clock cycles, which models the spacing between status reads. If the expected level does not appear within `MAX_POLLS` polls, the command is abandoned. The control word is then cleared and an error pulse is raised instead of done. The address and data values share the same 16-bit field of the control word.

Top module: `phyreg_hs_master`

## Requirements
- R1: After reset the control word is zero and busy, done and err are all low.
- R2: The control word carries the value in bits 15:0. Bit 16 captures the address, bit 17 captures the data, bit 18 strobes a write and bit 19 strobes a read. No more than one of bits 19:16 is ever set.
- R3: Every command opens with an address phase. The control word changes to the address alone, then to the address with bit 16 set. After the acknowledge is seen high it returns to the address alone. The block then waits for the acknowledge to be low.
- R4: A write continues through four control-word values in turn: the data alone, the data with bit 17, the data alone again, and bit 18 alone. It then shows the data alone and finally zero. Each strobe is held until the acknowledge is seen high, and each release waits for the acknowledge low.
- R5: A read continues from the address phase with bit 19 alone. When the acknowledge is seen high, status bits 15:0 are captured into rd_data. The control word then goes to zero and the block waits for the acknowledge low. rd_data keeps its value while the block is idle.
- R6: The acknowledge (status bit 16) is sampled only every POLL_GAP cycles of a waiting phase. A strobe whose acknowledge arrives D cycles after the strobe is raised stays high for (floor(D/POLL_GAP)+1)*POLL_GAP cycles.
- R7: If the acknowledge has not reached the awaited level by the MAX_POLLS-th poll of a phase, the command ends. err pulses for one cycle, done stays low and the control word returns to zero. The failing strobe or release has then lasted exactly MAX_POLLS*POLL_GAP cycles.
- R8: A command is accepted only while busy is low. cmd_valid raised while a command is in progress has no effect on the control word or on the PHY registers.
- R9: busy rises in the cycle after a command is accepted. It stays high until the cycle in which done or err is raised, where it is low. done and err are single-cycle pulses.
- R10: An acknowledge that first appears at exactly the MAX_POLLS-th poll is accepted. One that would first be seen at the next poll causes the timeout of R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request, taken when busy is low |
| cmd_write | input | 1 | 1 for a write, 0 for a read |
| cmd_addr | input | 16 | PHY register address |
| cmd_wdata | input | 16 | Write data |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle pulse on successful completion |
| err | output | 1 | One-cycle pulse on acknowledge timeout |
| rd_data | output | 16 | Data captured by the last successful read |
| phy_ctrl | output | 20 | Control word to the PHY (value, capture and strobe bits) |
| phy_stat | input | 17 | Status word from the PHY (bit 16 acknowledge, 15:0 read data) |

## Verification
The assertions assume that the status word reflects a PHY that answers each strobe with a level on bit 16. That level may arrive late, never, or may already be stuck high. The poll-spacing and timeout checks count cycles within a phase, so they assume the phase never changes except on a poll. The bench models the PHY with a delay line from the strobe bits to the acknowledge, plus stuck-low and stuck-high modes. Between commands it leaves enough idle cycles for that delay line to drain, so no stale acknowledge reaches the next command.

// File: rtl/phyreg_hs_pkg.sv
package phyreg_hs_pkg;

  localparam int BIT_CAP_ADDR = 16;
  localparam int BIT_CAP_DATA = 17;
  localparam int BIT_WR_STB   = 18;
  localparam int BIT_RD_STB   = 19;
  localparam int BIT_ACK      = 16;
  localparam int VAL_W        = BIT_CAP_ADDR;
  localparam int CW_W         = BIT_RD_STB + 1;
  localparam int SW_W         = BIT_ACK + 1;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_CAP,
    ST_ADDR_REL,
    ST_DATA,
    ST_DATA_CAP,
    ST_DATA_REL,
    ST_WR_STB,
    ST_WR_REL,
    ST_RD_STB,
    ST_RD_REL
  } step_e;

  function automatic logic [CW_W-1:0] strobe_bit(input int pos);
    logic [CW_W-1:0] v;
    v = '0;
    v[pos] = 1'b1;
    return v;
  endfunction

  // Control word driven while a given step is active.
  function automatic logic [CW_W-1:0] ctrl_for_step(input step_e s,
                                                    input logic [VAL_W-1:0] a,
                                                    input logic [VAL_W-1:0] d);
    logic [CW_W-1:0] av, dv;
    av = {{(CW_W-VAL_W){1'b0}}, a};
    dv = {{(CW_W-VAL_W){1'b0}}, d};
    case (s)
      ST_ADDR:     return av;
      ST_ADDR_CAP: return av | strobe_bit(BIT_CAP_ADDR);
      ST_ADDR_REL: return av;
      ST_DATA:     return dv;
      ST_DATA_CAP: return dv | strobe_bit(BIT_CAP_DATA);
      ST_DATA_REL: return dv;
      ST_WR_STB:   return strobe_bit(BIT_WR_STB);
      ST_WR_REL:   return dv;
      ST_RD_STB:   return strobe_bit(BIT_RD_STB);
      default:     return '0;
    endcase
  endfunction

  // Steps that hold until the acknowledge reaches a level.
  function automatic logic step_waits(input step_e s);
    case (s)
      ST_ADDR_CAP, ST_ADDR_REL, ST_DATA_CAP, ST_DATA_REL,
      ST_WR_STB, ST_WR_REL, ST_RD_STB, ST_RD_REL: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // Acknowledge level a waiting step looks for.
  function automatic logic step_level(input step_e s);
    case (s)
      ST_ADDR_CAP, ST_DATA_CAP, ST_WR_STB, ST_RD_STB: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic step_e step_after(input step_e s, input logic wr);
    case (s)
      ST_ADDR:     return ST_ADDR_CAP;
      ST_ADDR_CAP: return ST_ADDR_REL;
      ST_ADDR_REL: return wr ? ST_DATA : ST_RD_STB;
      ST_DATA:     return ST_DATA_CAP;
      ST_DATA_CAP: return ST_DATA_REL;
      ST_DATA_REL: return ST_WR_STB;
      ST_WR_STB:   return ST_WR_REL;
      ST_RD_STB:   return ST_RD_REL;
      default:     return ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/phyreg_poll_unit.sv
module phyreg_poll_unit #(
  parameter int POLL_GAP  = 4,
  parameter int MAX_POLLS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic want,
  input  logic ack,
  output logic poll_fire,
  output logic poll_hit,
  output logic timeout_fire
);
  localparam int GAP_W = (POLL_GAP > 1) ? $clog2(POLL_GAP) : 1;
  localparam int CNT_W = $clog2(MAX_POLLS + 1);

  logic [GAP_W-1:0] gap_cnt;
  logic [CNT_W-1:0] poll_cnt;

  assign poll_fire    = active && (gap_cnt == GAP_W'(POLL_GAP - 1));
  assign poll_hit     = poll_fire && (ack == want);
  assign timeout_fire = poll_fire && (ack != want) &&
                        (poll_cnt == CNT_W'(MAX_POLLS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || !active) begin
      gap_cnt  <= '0;
      poll_cnt <= '0;
    end else if (poll_fire) begin
      gap_cnt  <= '0;
      poll_cnt <= poll_hit ? '0 : poll_cnt + 1'b1;
    end else begin
      gap_cnt  <= gap_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/phyreg_step_seq.sv
module phyreg_step_seq
  import phyreg_hs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [VAL_W-1:0] cmd_addr,
  input  logic [VAL_W-1:0] cmd_wdata,
  input  logic             poll_hit,
  input  logic             timeout_fire,
  input  logic [VAL_W-1:0] stat_val,
  output step_e            step,
  output logic             wait_active,
  output logic             want_level,
  output logic             cmd_accept,
  output logic [CW_W-1:0]  ctrl_word,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [VAL_W-1:0] rd_data
);
  logic [VAL_W-1:0] addr_q, data_q;
  logic             wr_q;
  step_e            nxt;

  assign cmd_accept  = (step == ST_IDLE) && cmd_valid;
  assign wait_active = step_waits(step);
  assign want_level  = step_level(step);
  assign ctrl_word   = ctrl_for_step(step, addr_q, data_q);
  assign busy        = (step != ST_IDLE);
  assign nxt         = step_after(step, wr_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step    <= ST_IDLE;
      addr_q  <= '0;
      data_q  <= '0;
      wr_q    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      rd_data <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      if (step == ST_IDLE) begin
        if (cmd_valid) begin
          addr_q <= cmd_addr;
          data_q <= cmd_wdata;
          wr_q   <= cmd_write;
          step   <= ST_ADDR;
        end
      end else if (timeout_fire) begin
        step <= ST_IDLE;
        err  <= 1'b1;
      end else if (!wait_active) begin
        step <= nxt;
      end else if (poll_hit) begin
        if (step == ST_RD_STB) rd_data <= stat_val;
        step <= nxt;
        if (nxt == ST_IDLE) done <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/phyreg_hs_master.sv
module phyreg_hs_master
  import phyreg_hs_pkg::*;
#(
  parameter int POLL_GAP  = 4,
  parameter int MAX_POLLS = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic [VAL_W-1:0] cmd_addr,
  input  logic [VAL_W-1:0] cmd_wdata,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic [VAL_W-1:0] rd_data,
  output logic [CW_W-1:0]  phy_ctrl,
  input  logic [SW_W-1:0]  phy_stat
);
  step_e step;
  logic  wait_active, want_level, cmd_accept;
  logic  poll_fire, poll_hit, timeout_fire;

  phyreg_poll_unit #(.POLL_GAP(POLL_GAP), .MAX_POLLS(MAX_POLLS)) u_poll (
    .clk          (clk),
    .rst_n        (rst_n),
    .active       (wait_active),
    .want         (want_level),
    .ack          (phy_stat[BIT_ACK]),
    .poll_fire    (poll_fire),
    .poll_hit     (poll_hit),
    .timeout_fire (timeout_fire)
  );

  phyreg_step_seq u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_valid    (cmd_valid),
    .cmd_write    (cmd_write),
    .cmd_addr     (cmd_addr),
    .cmd_wdata    (cmd_wdata),
    .poll_hit     (poll_hit),
    .timeout_fire (timeout_fire),
    .stat_val     (phy_stat[VAL_W-1:0]),
    .step         (step),
    .wait_active  (wait_active),
    .want_level   (want_level),
    .cmd_accept   (cmd_accept),
    .ctrl_word    (phy_ctrl),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .rd_data      (rd_data)
  );
endmodule

// File: rtl/phyreg_hs_checker.sv
module phyreg_hs_checker
  import phyreg_hs_pkg::*;
#(
  parameter int POLL_GAP  = 4,
  parameter int MAX_POLLS = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_valid,
  input logic             busy,
  input logic             done,
  input logic             err,
  input logic [VAL_W-1:0] rd_data,
  input logic [CW_W-1:0]  phy_ctrl,
  input step_e            step,
  input logic             cmd_accept,
  input logic             poll_fire,
  input logic             timeout_fire
);
  step_e       last_step;
  logic [15:0] run;
  logic [15:0] age;

  assign age = (step != last_step) ? 16'd0 : run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      last_step <= ST_IDLE;
      run       <= '0;
    end else begin
      last_step <= step;
      run       <= age + 16'd1;
    end
  end

  assert_one_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(phy_ctrl[BIT_RD_STB:BIT_CAP_ADDR]));

  assert_poll_spacing_R6: assert property (@(posedge clk) disable iff (!rst_n)
    poll_fire |-> ((int'(age) + 1) % POLL_GAP) == 0);

  assert_timeout_window_R7: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_fire |-> (int'(age) + 1) == MAX_POLLS * POLL_GAP);

  assert_abort_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (phy_ctrl == '0) && !busy && !done);

  assert_accept_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy);

  assert_idle_stays_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> !busy);

  assert_rddata_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !cmd_valid) |=> $stable(rd_data));

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy && (phy_ctrl == '0));

  assert_busy_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (done || err));
endmodule

bind phyreg_hs_master phyreg_hs_checker #(
  .POLL_GAP  (POLL_GAP),
  .MAX_POLLS (MAX_POLLS)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_valid    (cmd_valid),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .rd_data      (rd_data),
  .phy_ctrl     (phy_ctrl),
  .step         (step),
  .cmd_accept   (cmd_accept),
  .poll_fire    (poll_fire),
  .timeout_fire (timeout_fire)
);

// File: tb/tb_phyreg_hs_master.sv
module tb_phyreg_hs_master;
  localparam int GAP  = 4;
  localparam int NPOL = 10;
  localparam logic [19:0] C_CA = 20'h1_0000;
  localparam logic [19:0] C_CD = 20'h2_0000;
  localparam logic [19:0] C_WR = 20'h4_0000;
  localparam logic [19:0] C_RD = 20'h8_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0, cmd_wdata = '0;
  logic        busy, done, err;
  logic [15:0] rd_data;
  logic [19:0] phy_ctrl;
  logic [16:0] phy_stat;

  always #2 clk = ~clk;

  phyreg_hs_master #(.POLL_GAP(GAP), .MAX_POLLS(NPOL)) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .busy(busy), .done(done),
    .err(err), .rd_data(rd_data), .phy_ctrl(phy_ctrl), .phy_stat(phy_stat)
  );

  // PHY model: acknowledge follows any strobe bit after a delay.
  int          ack_dly = 1;
  int          ack_mode = 0;   // 0 delayed, 1 stuck low, 2 stuck high
  logic [63:0] hist = '0;
  logic [15:0] m_addr = '0, m_data = '0;
  logic [15:0] mem [16];
  logic [3:0]  prev_stb = '0;
  logic        strobe, ack;

  assign strobe = |phy_ctrl[19:16];
  assign ack = (ack_mode == 1) ? 1'b0 : (ack_mode == 2) ? 1'b1 :
               (ack_dly == 0) ? strobe : hist[ack_dly-1];
  assign phy_stat = {ack, phy_ctrl[19] ? mem[m_addr[3:0]] : 16'h0000};

  initial for (int i = 0; i < 16; i++) mem[i] = 16'h0000;

  always @(posedge clk) begin
    hist     <= {hist[62:0], strobe};
    prev_stb <= phy_ctrl[19:16];
    if (phy_ctrl[16] && !prev_stb[0]) m_addr <= phy_ctrl[15:0];
    if (phy_ctrl[17] && !prev_stb[1]) m_data <= phy_ctrl[15:0];
    if (phy_ctrl[18] && !prev_stb[2]) mem[m_addr[3:0]] <= m_data;
  end

  // Control-word trace and capture-address hold length.
  logic [19:0] trace [16];
  int          trace_n = 0;
  logic [19:0] trace_last = '0;
  int          cap_run = 0, cap_len = 0;
  always @(negedge clk) begin
    if (phy_ctrl !== trace_last) begin
      if (trace_n < 16) trace[trace_n] = phy_ctrl;
      trace_n++;
      trace_last = phy_ctrl;
    end
    if (phy_ctrl[16]) cap_run++;
    else if (cap_run != 0) begin cap_len = cap_run; cap_run = 0; end
  end

  int n_chk = 0, n_err = 0, cyc = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  logic [19:0] exp_tr [16];
  int          exp_n;

  task automatic cmp_trace(input string req, input int from, input int upto);
    chk(trace_n == exp_n, req, "trace length", trace_n, exp_n);
    for (int i = from; i < upto && i < exp_n && i < trace_n; i++)
      chk(trace[i] == exp_tr[i], req, $sformatf("trace[%0d]", i), trace[i], exp_tr[i]);
  endtask

  task automatic settle();
    repeat (70) @(negedge clk);
  endtask

  task automatic start_cmd(input logic w, input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    trace_n = 0;
    cmd_valid = 1'b1; cmd_write = w; cmd_addr = a; cmd_wdata = d;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy == 1'b1, "R9", "busy after accept", busy, 1);
  endtask

  task automatic wait_end(output bit got_done, output bit got_err);
    int n = 0;
    while (!done && !err && n < 800) begin @(negedge clk); n++; end
    got_done = done; got_err = err;
    chk(done || err, "R9", "command ended", {done, err}, 2'b10);
    chk(busy == 1'b0, "R9", "busy low at end", busy, 0);
    @(negedge clk);
    chk(!done && !err, "R9", "end pulse one cycle", {done, err}, 0);
  endtask

  task automatic exp_write(input logic [15:0] a, input logic [15:0] d);
    exp_tr[0] = {4'h0, a}; exp_tr[1] = {4'h0, a} | C_CA; exp_tr[2] = {4'h0, a};
    exp_tr[3] = {4'h0, d}; exp_tr[4] = {4'h0, d} | C_CD; exp_tr[5] = {4'h0, d};
    exp_tr[6] = C_WR; exp_tr[7] = {4'h0, d}; exp_tr[8] = '0;
    exp_n = 9;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [15:0] d);
    bit gd, ge;
    start_cmd(1'b1, a, d);
    wait_end(gd, ge);
    chk(gd && !ge, "R4", "write done", {gd, ge}, 2'b10);
    exp_write(a, d);
    cmp_trace("R3", 0, 3);
    cmp_trace("R4", 3, 9);
    settle();
  endtask

  task automatic do_read(input logic [15:0] a, input logic [15:0] exp);
    bit gd, ge;
    start_cmd(1'b0, a, 16'h0);
    wait_end(gd, ge);
    chk(gd && !ge, "R5", "read done", {gd, ge}, 2'b10);
    exp_tr[0] = {4'h0, a}; exp_tr[1] = {4'h0, a} | C_CA; exp_tr[2] = {4'h0, a};
    exp_tr[3] = C_RD; exp_tr[4] = '0; exp_n = 5;
    cmp_trace("R5", 0, 5);
    chk(rd_data == exp, "R5", "read data", rd_data, exp);
    settle();
    chk(rd_data == exp, "R5", "read data held while idle", rd_data, exp);
  endtask

  task automatic t_reset();
    chk(phy_ctrl == '0, "R1", "ctrl at reset", phy_ctrl, 0);
    chk(busy == 1'b0, "R1", "busy at reset", busy, 0);
    chk(done == 1'b0, "R1", "done at reset", done, 0);
    chk(err == 1'b0, "R1", "err at reset", err, 0);
  endtask

  task automatic t_write_read();
    ack_mode = 0; ack_dly = 1;
    do_write(16'h0123, 16'hBEEF);
    chk(cap_len == GAP, "R6", "cap hold, delay 1", cap_len, GAP);
    do_write(16'hA5C7, 16'h5A3C);
    do_read(16'h0123, 16'hBEEF);
    do_read(16'h7FF7, 16'h5A3C);
    do_read(16'h0009, 16'h0000);
  endtask

  task automatic t_poll_spacing();
    ack_mode = 0; ack_dly = 5;
    do_write(16'h0042, 16'h1111);
    chk(cap_len == 2 * GAP, "R6", "cap hold, delay 5", cap_len, 2 * GAP);
    ack_dly = 1;
    do_read(16'h0042, 16'h1111);
  endtask

  task automatic t_busy_ignore();
    bit gd, ge;
    ack_mode = 0; ack_dly = 1;
    start_cmd(1'b1, 16'h0005, 16'hCAFE);
    repeat (3) @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = 16'h0006; cmd_wdata = 16'hDEAD;
    repeat (3) @(negedge clk);
    cmd_valid = 1'b0;
    wait_end(gd, ge);
    exp_write(16'h0005, 16'hCAFE);
    cmp_trace("R8", 0, 9);
    settle();
    chk(busy == 1'b0, "R8", "no second command started", busy, 0);
    do_read(16'h0006, 16'h0000);
    do_read(16'h0005, 16'hCAFE);
  endtask

  task automatic t_timeout_low();
    bit gd, ge;
    ack_mode = 1;
    start_cmd(1'b1, 16'h0011, 16'h2222);
    wait_end(gd, ge);
    chk(ge && !gd, "R7", "stuck-low gives err only", {gd, ge}, 2'b01);
    exp_tr[0] = 20'h00011; exp_tr[1] = 20'h00011 | C_CA; exp_tr[2] = '0; exp_n = 3;
    cmp_trace("R7", 0, 3);
    chk(cap_len == NPOL * GAP, "R7", "strobe length at timeout", cap_len, NPOL * GAP);
    chk(phy_ctrl == '0, "R7", "ctrl cleared", phy_ctrl, 0);
    ack_mode = 0; ack_dly = 1;
    settle();
    do_read(16'h0001, 16'h0000);
  endtask

  task automatic t_timeout_high();
    bit gd, ge;
    ack_mode = 2;
    start_cmd(1'b0, 16'h0033, 16'h0);
    wait_end(gd, ge);
    chk(ge && !gd, "R7", "stuck-high gives err", {gd, ge}, 2'b01);
    exp_tr[0] = 20'h00033; exp_tr[1] = 20'h00033 | C_CA; exp_tr[2] = 20'h00033;
    exp_tr[3] = '0; exp_n = 4;
    cmp_trace("R7", 0, 4);
    ack_mode = 0; ack_dly = 1;
    settle();
  endtask

  task automatic t_last_poll();
    bit gd, ge;
    ack_mode = 0; ack_dly = (NPOL - 1) * GAP;
    start_cmd(1'b1, 16'h000C, 16'h7777);
    wait_end(gd, ge);
    chk(gd && !ge, "R10", "ack at last poll accepted", {gd, ge}, 2'b10);
    chk(cap_len == NPOL * GAP, "R10", "cap hold at last poll", cap_len, NPOL * GAP);
    settle();
    ack_dly = NPOL * GAP;
    start_cmd(1'b1, 16'h000D, 16'h8888);
    wait_end(gd, ge);
    chk(ge && !gd, "R10", "ack one poll late fails", {gd, ge}, 2'b01);
    ack_dly = 1;
    settle();
    do_read(16'h000C, 16'h7777);
    do_read(16'h000D, 16'h0000);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_read();
    t_poll_spacing();
    t_busy_ignore();
    t_timeout_low();
    t_timeout_high();
    t_last_poll();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule